// File: doc/BRIEF.md
# Symmetric Ratio-Folded Edge Weight Generator

This block turns a pair of neighbouring pixels on one image axis into the weight that an edge-preserving recursive smoothing filter applies in that direction. Each pixel is first incremented by one. The ratio of the two results is X. The ideal weight is 0.01 / (0.00001 + (log10 X)^2). That curve is symmetric in log X, so a ratio below one gives the same weight as its reciprocal. The block therefore orders the two operands so that the folded ratio is at least one, and only the upper half of the curve is stored.

The folded ratio is never divided out. A bank of comparators tests it against a fixed set of edges by cross-multiplying: the ratio num/den reaches edge e exactly when num·2^F ≥ E·den, where E is the edge in units of 2^-F. The comparators form a thermometer code. Its population count selects one constant from a table of weights, and the weights are held with 6 fractional bits. One instance serves the horizontal axis and a second serves the vertical axis.

The result appears three clock cycles after the input strobe. The output word keeps its value between results.

Top module: `scpw_coef_gen`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly three rising clock edges, and a new input may be presented on every cycle.
- R2: When `pix_prev` equals `pix_next`, the result is 1000 in the output format (1000·64 = 64000), saturated to 2^OUT_W−1. At the default OUT_W = 16 the value is 64000.
- R3: The result is the same when the two pixel inputs are exchanged, because a ratio below one is folded onto its reciprocal.
- R4: With N = 23 edges and F = 6 fractional bits, edge k (k = 0..N−1) is E_k = 64 + ceil(64·(k+1)²/N²) in units of 1/64. If this value does not exceed E_(k−1), it is raised to E_(k−1)+1, with E_(−1) = 64. The edges therefore run from 65 up to 128 and are dense near X = 1. The segment index is the number of edges for which X ≥ E_k/64; a ratio exactly equal to an edge counts as having reached it.
- R5: For segment index i < N, the result is floor(64·w(E_i/64)), where w(x) = 0.01/(0.00001 + log10(x)²). This is the curve taken at the segment's upper edge.
- R6: A folded ratio of 2 or more selects index N. Its result is floor(64·w(2)) = 7.
- R7: While `rst_n` is low, `out_valid` is 0 and `weight` is 0.
- R8: On every cycle in which `out_valid` is 0, `weight` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks a pixel pair to process |
| pix_prev | input | 8 | Neighbour before the centre pixel on this axis |
| pix_next | input | 8 | Neighbour after the centre pixel on this axis |
| out_valid | output | 1 | Marks a new weight on `weight` |
| weight | output | 16 | Weight, unsigned, 6 fractional bits |

## Verification
The timing assertions assume that `in_valid` is a clean 0 or 1 on every clock edge after reset is released, and that the pixel inputs are defined whenever the strobe is high. The bench holds both inputs at zero through reset and changes them only on falling edges. The edge assertions assume an increasing edge set, so that the comparator outputs always form a prefix of ones. The stimulus covers both orderings of each pair, ratios that sit exactly on an edge, and ratios at and beyond 2.

// File: rtl/scpw_pkg.sv
package scpw_pkg;

  // Edge k of the table in units of 2^-frac, spread quadratically over [1,2]
  // and forced strictly increasing.
  function automatic int edge_at(int k, int n, int frac);
    int one;
    int e;
    int prev;
    one  = 1 << frac;
    prev = one;
    e    = one;
    for (int j = 0; j <= k; j++) begin
      e = one + (one * (j + 1) * (j + 1) + n * n - 1) / (n * n);
      if (e <= prev) e = prev + 1;
      prev = e;
    end
    return e;
  endfunction

  // Weight curve sampled at ratio e/2^efrac, truncated to ofrac fractional bits.
  function automatic int curve_q(int e, int efrac, int ofrac, int ow);
    real x;
    real lg;
    real w;
    real q;
    int  lim;
    x   = real'(e) / real'(1 << efrac);
    lg  = $log10(x);
    w   = 1.0e-2 / (1.0e-5 + lg * lg);
    q   = $floor(w * real'(1 << ofrac));
    lim = (1 << ow) - 1;
    if (q > real'(lim)) return lim;
    return $rtoi(q);
  endfunction

  // Value returned for equal neighbours: 1000, saturated to the output width.
  function automatic int sat_top(int ow, int ofrac);
    int v;
    int lim;
    v   = 1000 << ofrac;
    lim = (1 << ow) - 1;
    return (v > lim) ? lim : v;
  endfunction

endpackage

// File: rtl/scpw_fold.sv
module scpw_fold #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] pix_a,
  input  logic [PIX_W-1:0] pix_b,
  output logic             s1_valid,
  output logic [PIX_W:0]   s1_num,
  output logic [PIX_W:0]   s1_den,
  output logic             s1_eq
);
  localparam int OPW = PIX_W + 1;

  logic [OPW-1:0] a_inc;
  logic [OPW-1:0] b_inc;
  logic           swap_evt;
  logic           equal_evt;

  assign a_inc     = {1'b0, pix_a} + OPW'(1);
  assign b_inc     = {1'b0, pix_b} + OPW'(1);
  assign swap_evt  = a_inc < b_inc;
  assign equal_evt = a_inc == b_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_num   <= '0;
      s1_den   <= '0;
      s1_eq    <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_num <= swap_evt ? b_inc : a_inc;
        s1_den <= swap_evt ? a_inc : b_inc;
        s1_eq  <= equal_evt;
      end
    end
  end
endmodule

// File: rtl/scpw_cmp_array.sv
module scpw_cmp_array
  import scpw_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int N_EDGES   = 23,
  parameter int EDGE_FRAC = 6,
  parameter int IDX_W     = $clog2(N_EDGES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s1_valid,
  input  logic [PIX_W:0]     s1_num,
  input  logic [PIX_W:0]     s1_den,
  input  logic               s1_eq,
  output logic [N_EDGES-1:0] therm,
  output logic               s2_valid,
  output logic [IDX_W-1:0]   s2_idx,
  output logic               s2_eq
);
  localparam int OPW = PIX_W + 1;
  localparam int EW  = EDGE_FRAC + 2;
  localparam int PW  = OPW + EW;

  logic [PW-1:0]    lhs;
  logic [IDX_W-1:0] count_c;

  assign lhs = PW'({s1_num, {EDGE_FRAC{1'b0}}});

  for (genvar k = 0; k < N_EDGES; k++) begin : g_cmp
    localparam int EK = edge_at(k, N_EDGES, EDGE_FRAC);
    logic [PW-1:0] rhs;
    assign rhs      = PW'(s1_den) * PW'(EK);
    assign therm[k] = lhs >= rhs;
  end

  always_comb begin
    count_c = '0;
    for (int k = 0; k < N_EDGES; k++) begin
      count_c = count_c + IDX_W'(therm[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_idx   <= '0;
      s2_eq    <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_idx <= count_c;
        s2_eq  <= s1_eq;
      end
    end
  end
endmodule

// File: rtl/scpw_lut.sv
module scpw_lut
  import scpw_pkg::*;
#(
  parameter int N_EDGES   = 23,
  parameter int EDGE_FRAC = 6,
  parameter int OUT_FRAC  = 6,
  parameter int OUT_W     = 16,
  parameter int IDX_W     = $clog2(N_EDGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s2_valid,
  input  logic [IDX_W-1:0] s2_idx,
  input  logic             s2_eq,
  output logic             out_valid,
  output logic [OUT_W-1:0] weight
);
  localparam int TOP_E = 2 << EDGE_FRAC;
  localparam logic [OUT_W-1:0] SATV = OUT_W'(sat_top(OUT_W, OUT_FRAC));

  logic [OUT_W-1:0] table_w [0:N_EDGES];
  logic [OUT_W-1:0] sel_w;

  for (genvar i = 0; i <= N_EDGES; i++) begin : g_seg
    localparam int EI = (i < N_EDGES) ? edge_at(i, N_EDGES, EDGE_FRAC) : TOP_E;
    localparam int VI = curve_q(EI, EDGE_FRAC, OUT_FRAC, OUT_W);
    assign table_w[i] = OUT_W'(VI);
  end

  always_comb begin
    sel_w = table_w[N_EDGES];
    for (int i = 0; i <= N_EDGES; i++) begin
      if (s2_idx == IDX_W'(i)) sel_w = table_w[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      weight    <= '0;
    end else begin
      out_valid <= s2_valid;
      if (s2_valid) weight <= s2_eq ? SATV : sel_w;
    end
  end
endmodule

// File: rtl/scpw_coef_gen.sv
module scpw_coef_gen #(
  parameter int PIX_W     = 8,
  parameter int N_EDGES   = 23,
  parameter int EDGE_FRAC = 6,
  parameter int OUT_FRAC  = 6,
  parameter int OUT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] pix_prev,
  input  logic [PIX_W-1:0] pix_next,
  output logic             out_valid,
  output logic [OUT_W-1:0] weight
);
  localparam int IDX_W = $clog2(N_EDGES + 1);

  logic               s1_valid;
  logic [PIX_W:0]     s1_num;
  logic [PIX_W:0]     s1_den;
  logic               s1_eq;
  logic [N_EDGES-1:0] cmp_therm;
  logic               s2_valid;
  logic [IDX_W-1:0]   s2_idx;
  logic               s2_eq;

  scpw_fold #(.PIX_W(PIX_W)) u_fold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pix_a(pix_prev), .pix_b(pix_next),
    .s1_valid(s1_valid), .s1_num(s1_num), .s1_den(s1_den), .s1_eq(s1_eq)
  );

  scpw_cmp_array #(
    .PIX_W(PIX_W), .N_EDGES(N_EDGES), .EDGE_FRAC(EDGE_FRAC), .IDX_W(IDX_W)
  ) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .s1_valid(s1_valid), .s1_num(s1_num), .s1_den(s1_den), .s1_eq(s1_eq),
    .therm(cmp_therm), .s2_valid(s2_valid), .s2_idx(s2_idx), .s2_eq(s2_eq)
  );

  scpw_lut #(
    .N_EDGES(N_EDGES), .EDGE_FRAC(EDGE_FRAC), .OUT_FRAC(OUT_FRAC),
    .OUT_W(OUT_W), .IDX_W(IDX_W)
  ) u_lut (
    .clk(clk), .rst_n(rst_n),
    .s2_valid(s2_valid), .s2_idx(s2_idx), .s2_eq(s2_eq),
    .out_valid(out_valid), .weight(weight)
  );
endmodule

// File: rtl/scpw_coef_gen_chk.sv
module scpw_coef_gen_chk
  import scpw_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int N_EDGES   = 23,
  parameter int EDGE_FRAC = 6,
  parameter int OUT_FRAC  = 6,
  parameter int OUT_W     = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [PIX_W-1:0]   pix_prev,
  input logic [PIX_W-1:0]   pix_next,
  input logic               out_valid,
  input logic [OUT_W-1:0]   weight,
  input logic               fold_valid,
  input logic [PIX_W:0]     fold_num,
  input logic [PIX_W:0]     fold_den,
  input logic [N_EDGES-1:0] therm
);
  localparam logic [OUT_W-1:0] SATV = OUT_W'(sat_top(OUT_W, OUT_FRAC));
  localparam logic [OUT_W-1:0] TOPV =
    OUT_W'(curve_q(2 << EDGE_FRAC, EDGE_FRAC, OUT_FRAC, OUT_W));

  logic [1:0]     cyc;
  logic           in_eq;
  logic           in_over2;
  logic [PIX_W:0] inc_prev;
  logic [PIX_W:0] inc_next;

  assign inc_prev = {1'b0, pix_prev} + (PIX_W + 1)'(1);
  assign inc_next = {1'b0, pix_next} + (PIX_W + 1)'(1);
  assign in_eq    = in_valid && (pix_prev == pix_next);
  assign in_over2 = in_valid && (({1'b0, inc_prev} > {inc_next, 1'b0}) ||
                                 ({1'b0, inc_next} > {inc_prev, 1'b0}));

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_LATENCY_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R1

  AST_EQUAL_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc == 2'd3) && $past(in_eq, 3)) |-> (weight == SATV)); // R2

  AST_FOLD_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    fold_valid |-> (fold_num >= fold_den)); // R3

  AST_THERM_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    fold_valid |-> ((therm & (therm + N_EDGES'(1))) == '0)); // R4

  AST_OVER_TWO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc == 2'd3) && $past(in_over2, 3)) |-> (weight == TOPV)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc != 2'd0) && !out_valid) |-> $stable(weight)); // R8
endmodule

bind scpw_coef_gen scpw_coef_gen_chk #(
  .PIX_W(PIX_W), .N_EDGES(N_EDGES), .EDGE_FRAC(EDGE_FRAC),
  .OUT_FRAC(OUT_FRAC), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .pix_prev(pix_prev), .pix_next(pix_next),
  .out_valid(out_valid), .weight(weight),
  .fold_valid(s1_valid), .fold_num(s1_num), .fold_den(s1_den),
  .therm(cmp_therm)
);

// File: tb/scpw_coef_gen_test.sv
module scpw_coef_gen_test;
  localparam int NE = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  pix_prev = 8'd0;
  logic [7:0]  pix_next = 8'd0;
  logic        out_valid;
  logic [15:0] weight;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scpw_coef_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pix_prev(pix_prev), .pix_next(pix_next),
    .out_valid(out_valid), .weight(weight)
  );

  // Stimulus pairs {prev, next}
  localparam logic [15:0] VEC [0:15] = '{
    {8'd0,   8'd0},   {8'd255, 8'd255}, {8'd255, 8'd0},  {8'd0,   8'd255},
    {8'd100, 8'd99},  {8'd99,  8'd100}, {8'd128, 8'd63}, {8'd127, 8'd63},
    {8'd64,  8'd63},  {8'd63,  8'd64},  {8'd10,  8'd5},  {8'd200, 8'd150},
    {8'd30,  8'd20},  {8'd17,  8'd16},  {8'd3,   8'd1},  {8'd2,   8'd1}
  };

  function automatic int bench_edge(int k);
    int e;
    int p;
    p = 64;
    e = 64;
    for (int j = 0; j <= k; j++) begin
      e = 64 + $rtoi($ceil(64.0 * real'((j + 1) * (j + 1)) / real'(NE * NE)));
      if (e <= p) e = p + 1;
      p = e;
    end
    return e;
  endfunction

  function automatic int bench_w(int e64);
    real r;
    real lg;
    real w;
    int  q;
    r  = real'(e64) / 64.0;
    lg = $log10(r);
    w  = 0.01 / (0.00001 + lg * lg);
    q  = $rtoi(w * 64.0);
    if (q > 65535) q = 65535;
    return q;
  endfunction

  function automatic int expect_w(int p, int n);
    int a;
    int b;
    int hi;
    int lo;
    int cnt;
    a = p + 1;
    b = n + 1;
    if (a == b) return 64000;
    hi = (a > b) ? a : b;
    lo = (a > b) ? b : a;
    cnt = 0;
    for (int k = 0; k < NE; k++) begin
      if (real'(hi) / real'(lo) >= real'(bench_edge(k)) / 64.0) cnt++;
    end
    return (cnt < NE) ? bench_w(bench_edge(cnt)) : bench_w(128);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic run_one(input int p, input int n, input string req);
    int e;
    e = expect_w(p, n);
    @(negedge clk);
    pix_prev = 8'(p);
    pix_next = 8'(n);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R1", int'(out_valid), 1);
    check(int'(weight) == e, req, int'(weight), e);
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    int held;
    int ex [0:3];
    // R7: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", int'(out_valid), 0);
    check(weight == 16'd0, "R7", int'(weight), 0);
    rst_n = 1'b1;

    // Table walk: R5 general values, R3 mirror pairs
    for (int i = 0; i < 16; i++) begin
      run_one(int'(VEC[i][15:8]), int'(VEC[i][7:0]), "R5");
    end

    // R2: equal neighbours saturate to 64000
    run_one(77, 77, "R2");
    check(int'(weight) == 64000, "R2", int'(weight), 64000);

    // R3: exchanged inputs give the same weight
    run_one(40, 25, "R3");
    held = int'(weight);
    run_one(25, 40, "R3");
    check(int'(weight) == held, "R3", int'(weight), held);

    // R4: ratio exactly on the first edge (65/64) reaches it; just below does not
    run_one(64, 63, "R4");
    check(int'(weight) == bench_w(bench_edge(1)), "R4", int'(weight), bench_w(bench_edge(1)));
    run_one(129, 128, "R4");
    check(int'(weight) == bench_w(bench_edge(0)), "R4", int'(weight), bench_w(bench_edge(0)));

    // R6: ratio of exactly 2 and beyond 2 give 7
    run_one(127, 63, "R6");
    check(int'(weight) == 7, "R6", int'(weight), 7);
    run_one(255, 0, "R6");
    check(int'(weight) == 7, "R6", int'(weight), 7);

    // R8: weight holds while idle
    held = int'(weight);
    repeat (5) begin
      @(negedge clk);
      check(out_valid == 1'b0 && int'(weight) == held, "R8", int'(weight), held);
    end

    // R1: back-to-back inputs, one result per cycle three edges later
    ex[0] = expect_w(10, 200);
    ex[1] = expect_w(90, 91);
    ex[2] = expect_w(5, 5);
    ex[3] = expect_w(250, 1);
    @(negedge clk);
    pix_prev = 8'd10;  pix_next = 8'd200; in_valid = 1'b1;
    @(negedge clk);
    pix_prev = 8'd90;  pix_next = 8'd91;
    @(negedge clk);
    pix_prev = 8'd5;   pix_next = 8'd5;
    @(negedge clk);
    pix_prev = 8'd250; pix_next = 8'd1;
    check(out_valid == 1'b1 && int'(weight) == ex[0], "R1", int'(weight), ex[0]);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1 && int'(weight) == ex[1], "R1", int'(weight), ex[1]);
    @(negedge clk);
    check(out_valid == 1'b1 && int'(weight) == ex[2], "R1", int'(weight), ex[2]);
    @(negedge clk);
    check(out_valid == 1'b1 && int'(weight) == ex[3], "R1", int'(weight), ex[3]);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);

    // R7: reset again clears the outputs
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && weight == 16'd0, "R7", int'(weight), 0);
    finish_up();
  end
endmodule